// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the register slave for the control layer of a multi-channel descriptor DMA engine. A simple device-control bus (address, read strobe, write strobe, 32-bit write data, registered 32-bit read data) reaches a global configuration word, an interrupt-enable word, four channel-activation words (a set and a reset image for each direction), and five status words. It also reaches a table of descriptor pointers for every transmit and every receive channel, and a buffer-size byte for every receive channel.

The status words clear when software writes ones to them. Set pulses from the DMA datapath raise their bits, and a pulse wins over a software clear in the same cycle, so no event is dropped. A soft reset, requested through the top bit of the configuration word, returns the control and status words to their defaults. The channel counts are parameters from 1 to 32. Table addresses past the configured count behave as holes in the map.

Top module: `dmac_ctl_regs`

## Requirements
- R1: After a synchronous active-low reset, the configuration word at 0x180 reads 0x0007C000. The error status (0x181), interrupt enable (0x182), activation words and every other status word read zero. `cfg_o` and `int_en_o` show the same values.
- R2: `bus_rdata` takes the addressed value on the clock edge that samples `bus_rd` and holds it until the next read. A read and a write in the same cycle return the value from before the write.
- R3: A write to 0x180 stores the data ANDed with 0x00FFC087. Bit 31 therefore never reads back as one.
- R4: A write to 0x180 with bit 31 set first clears the interrupt enable, the four activation words and the five status words, and then stores the masked value. Pointer and size tables keep their contents.
- R5: The interrupt enable at 0x182 keeps only bits 4:0.
- R6: Transmit activation set/reset at 0x184/0x185 keep bits 31:28. Receive activation set/reset at 0x190/0x191 keep bits 31:30.
- R7: The status words at 0x181 (error), 0x186 (transmit end-of-buffer), 0x187 (transmit descriptor error), 0x192 (receive end-of-buffer) and 0x193 (receive descriptor error) clear each bit written as one and keep each bit written as zero.
- R8: A one on a bit of a status set input sets that status bit on the next edge. This holds even when the same cycle carries a software clear or a soft reset.
- R9: Transmit pointer i sits at 0x1A0+i for i below TX_CH, and receive pointer i sits at 0x1C0+i for i below RX_CH. Each stores all 32 bits.
- R10: Receive buffer size i sits at 0x1E0+i for i below RX_CH and keeps only bits 7:0.
- R11: Reads of unmapped addresses return zero. Writes there change nothing. Table addresses at or past the channel count are unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| err_set | input | 32 | Set pulses for the error status |
| tx_eob_set | input | 32 | Set pulses for transmit end-of-buffer status |
| tx_derr_set | input | 32 | Set pulses for transmit descriptor-error status |
| rx_eob_set | input | 32 | Set pulses for receive end-of-buffer status |
| rx_derr_set | input | 32 | Set pulses for receive descriptor-error status |
| cfg_o | output | 32 | Current configuration word |
| int_en_o | output | 32 | Current interrupt-enable word |

## Verification
Read data is due one edge after the cycle that carries `bus_rd`. Configuration and interrupt-enable writes show on `cfg_o` and `int_en_o` one edge after the write cycle. A status set pulse shows up on any read issued in the cycle after the pulse. The bench drives every input on the falling edge and keeps a behavioural model that it steps on the rising edge. On every falling edge it compares `bus_rdata`, `cfg_o` and `int_en_o` against that model, so each result is checked exactly at the cycle it is due. Directed reads also compare against literal expected values.

// File: rtl/dmac_ctl_pkg.sv
// Package: address map, keep-masks and reset values of the DMA control register file.
// Assumes a word-addressed bus; all addresses are register indices.
package dmac_ctl_pkg;
    localparam int unsigned A_CFG    = 32'h180;
    localparam int unsigned A_IER    = 32'h182;
    localparam int unsigned A_TXSET  = 32'h184;
    localparam int unsigned A_TXRST  = 32'h185;
    localparam int unsigned A_RXSET  = 32'h190;
    localparam int unsigned A_RXRST  = 32'h191;
    localparam int unsigned A_TXPTR  = 32'h1A0;
    localparam int unsigned A_RXPTR  = 32'h1C0;
    localparam int unsigned A_RXSIZE = 32'h1E0;

    localparam int NUM_STAT = 5;
    // status words: error, tx end-of-buffer, tx desc error, rx end-of-buffer, rx desc error
    localparam int unsigned A_STAT [NUM_STAT] = '{32'h181, 32'h186, 32'h187, 32'h192, 32'h193};

    localparam logic [31:0] CFG_RESET  = 32'h0007_C000;
    localparam logic [31:0] CFG_KEEP   = 32'h00FF_C087;
    localparam logic [31:0] IER_KEEP   = 32'h0000_001F;
    localparam logic [31:0] TXACT_KEEP = 32'hF000_0000;
    localparam logic [31:0] RXACT_KEEP = 32'hC000_0000;
    localparam logic [31:0] SIZE_KEEP  = 32'h0000_00FF;
    localparam logic [31:0] PTR_KEEP   = 32'hFFFF_FFFF;
    localparam int          SOFT_BIT   = 31;
endpackage

// File: rtl/dmac_w1c_status.sv
// Module: one 32-bit status word. Software clears bits by writing ones,
// hardware sets bits with pulses; a pulse beats a same-cycle clear or soft reset.
// Assumes clr_wr is already qualified by the address decode.
module dmac_w1c_status (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        clr_wr,
    input  logic [31:0] wdata,
    input  logic [31:0] set,
    output logic [31:0] q
);
    logic [31:0] kept;

    // Bits surviving software action this cycle.
    always_comb begin
        if (soft_rst)
            kept = '0;
        else if (clr_wr)
            kept = q & ~wdata;
        else
            kept = q;
    end

    // Status register update, set pulses last so they win.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= kept | set;
    end

    // R8: every pulsed bit is present after the edge
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((q & $past(set)) == $past(set)));

    // R7: written ones are gone unless re-set
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !soft_rst && set == '0) |=> ((q & $past(wdata)) == '0));
endmodule

// File: rtl/dmac_chan_table.sv
// Module: per-channel table of COUNT words mapped from BASE. Writes keep only
// KEEP bits; addresses outside [BASE, BASE+COUNT) are not claimed (hit low).
// Assumes 1 <= COUNT <= 32. Not affected by soft reset.
module dmac_chan_table #(
    parameter int unsigned BASE  = 32'h1A0,
    parameter int          COUNT = 4,
    parameter logic [31:0] KEEP  = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] addr,
    input  logic        wr,
    input  logic [31:0] wdata,
    output logic        hit,
    output logic [31:0] rdata
);
    localparam int IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1;

    logic [IDX_W-1:0] idx;
    logic [31:0]      ent [COUNT];

    // Address window decode.
    always_comb begin
        hit   = (addr >= BASE) && (addr < BASE + 32'(COUNT));
        idx   = IDX_W'(addr - BASE);
        rdata = hit ? ent[idx] : '0;
    end

    for (genvar i = 0; i < COUNT; i++) begin : g_ent
        // Entry i storage.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[i] <= '0;
            else if (wr && hit && idx == IDX_W'(i))
                ent[i] <= wdata & KEEP;
        end

        // R11: an entry changes only through a write that addresses it
        p_entry_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr && hit && idx == IDX_W'(i)) |=> $stable(ent[i]));
    end
endmodule

// File: rtl/dmac_ctl_regs.sv
// Module: control/status register file of a descriptor DMA channel layer.
// Decodes the bus, holds config, interrupt enable, activation words,
// five W1C status words and three per-channel tables; read data is registered.
// Assumes TX_CH and RX_CH in 1..32 and ADDR_W wide enough for 0x1FF.
module dmac_ctl_regs
    import dmac_ctl_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int TX_CH  = 4,
    parameter int RX_CH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       err_set,
    input  logic [31:0]       tx_eob_set,
    input  logic [31:0]       tx_derr_set,
    input  logic [31:0]       rx_eob_set,
    input  logic [31:0]       rx_derr_set,
    output logic [31:0]       cfg_o,
    output logic [31:0]       int_en_o
);
    localparam int NUM_ACT = 4;
    localparam int unsigned A_ACT [NUM_ACT] = '{A_TXSET, A_TXRST, A_RXSET, A_RXRST};
    localparam logic [31:0] K_ACT [NUM_ACT] = '{TXACT_KEEP, TXACT_KEEP, RXACT_KEEP, RXACT_KEEP};

    initial begin
        a_tx_count: assert (TX_CH >= 1 && TX_CH <= 32);
        a_rx_count: assert (RX_CH >= 1 && RX_CH <= 32);
    end

    logic [31:0] addr32;
    logic        soft_rst;
    logic [31:0] cfg_q, ier_q;
    logic [31:0] act_q  [NUM_ACT];
    logic [31:0] st_q   [NUM_STAT];
    logic [31:0] st_set [NUM_STAT];
    logic        txp_hit, rxp_hit, rxs_hit;
    logic [31:0] txp_rd, rxp_rd, rxs_rd;
    logic [31:0] rd_mux;

    // Widen the address and decode the soft-reset request.
    always_comb begin
        addr32   = 32'(bus_addr);
        soft_rst = bus_wr && addr32 == A_CFG && bus_wdata[SOFT_BIT];
    end

    // Configuration word, masked on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= CFG_RESET;
        else if (bus_wr && addr32 == A_CFG)
            cfg_q <= bus_wdata & CFG_KEEP;
    end

    // Interrupt enable, cleared by soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            ier_q <= '0;
        else if (bus_wr && addr32 == A_IER)
            ier_q <= bus_wdata & IER_KEEP;
    end

    for (genvar a = 0; a < NUM_ACT; a++) begin : g_act
        // Activation word a, masked, cleared by soft reset.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst)
                act_q[a] <= '0;
            else if (bus_wr && addr32 == A_ACT[a])
                act_q[a] <= bus_wdata & K_ACT[a];
        end
    end

    // Gather the hardware set pulses in status order.
    always_comb begin
        st_set[0] = err_set;
        st_set[1] = tx_eob_set;
        st_set[2] = tx_derr_set;
        st_set[3] = rx_eob_set;
        st_set[4] = rx_derr_set;
    end

    for (genvar s = 0; s < NUM_STAT; s++) begin : g_stat
        dmac_w1c_status u_stat (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .clr_wr   (bus_wr && addr32 == A_STAT[s]),
            .wdata    (bus_wdata),
            .set      (st_set[s]),
            .q        (st_q[s])
        );
    end

    dmac_chan_table #(.BASE(A_TXPTR), .COUNT(TX_CH), .KEEP(PTR_KEEP)) u_txptr (
        .clk(clk), .rst_n(rst_n), .addr(addr32), .wr(bus_wr), .wdata(bus_wdata),
        .hit(txp_hit), .rdata(txp_rd));

    dmac_chan_table #(.BASE(A_RXPTR), .COUNT(RX_CH), .KEEP(PTR_KEEP)) u_rxptr (
        .clk(clk), .rst_n(rst_n), .addr(addr32), .wr(bus_wr), .wdata(bus_wdata),
        .hit(rxp_hit), .rdata(rxp_rd));

    dmac_chan_table #(.BASE(A_RXSIZE), .COUNT(RX_CH), .KEEP(SIZE_KEEP)) u_rxsize (
        .clk(clk), .rst_n(rst_n), .addr(addr32), .wr(bus_wr), .wdata(bus_wdata),
        .hit(rxs_hit), .rdata(rxs_rd));

    // Read multiplexer over every mapped word; zero elsewhere.
    always_comb begin
        rd_mux = '0;
        if (addr32 == A_CFG) rd_mux = cfg_q;
        if (addr32 == A_IER) rd_mux = ier_q;
        for (int a = 0; a < NUM_ACT; a++)
            if (addr32 == A_ACT[a]) rd_mux = act_q[a];
        for (int s = 0; s < NUM_STAT; s++)
            if (addr32 == A_STAT[s]) rd_mux = st_q[s];
        if (txp_hit) rd_mux = txp_rd;
        if (rxp_hit) rd_mux = rxp_rd;
        if (rxs_hit) rd_mux = rxs_rd;
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    assign cfg_o    = cfg_q;
    assign int_en_o = ier_q;

    // R2: read data moves only after a read strobe
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R5: interrupt enable write lands masked to bits 4:0
    p_ier_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && addr32 == A_IER) |=> (int_en_o == ($past(bus_wdata) & 32'h1F)));

    // R4: soft reset empties the interrupt enable
    p_soft_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (int_en_o == '0));
endmodule

// File: tb/dmac_ctl_regs_bench.sv
`timescale 1ns/1ps
module dmac_ctl_regs_bench;
    localparam int TX_CH = 4;
    localparam int RX_CH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] err_set = '0, tx_eob_set = '0, tx_derr_set = '0, rx_eob_set = '0, rx_derr_set = '0;
    logic [31:0] cfg_o, int_en_o;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    dmac_ctl_regs #(.ADDR_W(10), .TX_CH(TX_CH), .RX_CH(RX_CH)) u_dmac_ctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_set(err_set),
        .tx_eob_set(tx_eob_set), .tx_derr_set(tx_derr_set), .rx_eob_set(rx_eob_set),
        .rx_derr_set(rx_derr_set), .cfg_o(cfg_o), .int_en_o(int_en_o));

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_cfg, m_ier, m_rdata;
    logic [31:0] m_act [4];   // txset, txrst, rxset, rxrst
    logic [31:0] m_st  [5];   // err, txeob, txderr, rxeob, rxderr
    logic [31:0] m_txp [32];
    logic [31:0] m_rxp [32];
    logic [31:0] m_rxs [32];
    bit          started = 0;

    function automatic int stat_index(int a);
        case (a)
            'h181: return 0; 'h186: return 1; 'h187: return 2;
            'h192: return 3; 'h193: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic int act_index(int a);
        case (a)
            'h184: return 0; 'h185: return 1; 'h190: return 2; 'h191: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] m_read(int a);
        if (a == 'h180) return m_cfg;
        if (a == 'h182) return m_ier;
        if (act_index(a) >= 0) return m_act[act_index(a)];
        if (stat_index(a) >= 0) return m_st[stat_index(a)];
        if (a >= 'h1A0 && a < 'h1A0 + TX_CH) return m_txp[a - 'h1A0];
        if (a >= 'h1C0 && a < 'h1C0 + RX_CH) return m_rxp[a - 'h1C0];
        if (a >= 'h1E0 && a < 'h1E0 + RX_CH) return m_rxs[a - 'h1E0];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_cfg = 32'h0007C000; m_ier = 0; m_rdata = 0;
            for (int i = 0; i < 4; i++) m_act[i] = 0;
            for (int i = 0; i < 5; i++) m_st[i] = 0;
            for (int i = 0; i < 32; i++) begin m_txp[i] = 0; m_rxp[i] = 0; m_rxs[i] = 0; end
        end else begin
            int a;
            a = int'(bus_addr);
            if (bus_rd) m_rdata = m_read(a);
            if (bus_wr) begin
                if (a == 'h180) begin
                    if (bus_wdata[31]) begin
                        m_ier = 0;
                        for (int i = 0; i < 4; i++) m_act[i] = 0;
                        for (int i = 0; i < 5; i++) m_st[i] = 0;
                    end
                    m_cfg = bus_wdata & 32'h00FFC087;
                end
                if (a == 'h182) m_ier = bus_wdata & 32'h1F;
                if (act_index(a) >= 0)
                    m_act[act_index(a)] = bus_wdata & ((act_index(a) < 2) ? 32'hF0000000 : 32'hC0000000);
                if (stat_index(a) >= 0) m_st[stat_index(a)] = m_st[stat_index(a)] & ~bus_wdata;
                if (a >= 'h1A0 && a < 'h1A0 + TX_CH) m_txp[a - 'h1A0] = bus_wdata;
                if (a >= 'h1C0 && a < 'h1C0 + RX_CH) m_rxp[a - 'h1C0] = bus_wdata;
                if (a >= 'h1E0 && a < 'h1E0 + RX_CH) m_rxs[a - 'h1E0] = bus_wdata & 32'hFF;
            end
            m_st[0] |= err_set; m_st[1] |= tx_eob_set; m_st[2] |= tx_derr_set;
            m_st[3] |= rx_eob_set; m_st[4] |= rx_derr_set;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(cur_req, "model rdata", bus_rdata, m_rdata);
            chk(cur_req, "model cfg_o", cfg_o, m_cfg);
            chk(cur_req, "model int_en_o", int_en_o, m_ier);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr = 10'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(int a, logic [31:0] exp, string req);
        @(negedge clk);
        bus_addr = 10'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(req, $sformatf("read %h", a), bus_rdata, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cur_req = "R1";
        rd_chk('h180, 32'h0007C000, "R1");
        rd_chk('h181, 32'h0, "R1");
        rd_chk('h182, 32'h0, "R1");
        rd_chk('h186, 32'h0, "R1");
        chk("R1", "cfg_o", cfg_o, 32'h0007C000);

        // R3 config mask
        cur_req = "R3";
        wr('h180, 32'h7FFFFFFF);
        rd_chk('h180, 32'h00FFC087, "R3");

        // R5 interrupt enable mask
        cur_req = "R5";
        wr('h182, 32'hFFFFFFFF);
        rd_chk('h182, 32'h1F, "R5");

        // R6 activation masks
        cur_req = "R6";
        wr('h184, 32'hFFFFFFFF); wr('h185, 32'hFFFFFFFF);
        wr('h190, 32'hFFFFFFFF); wr('h191, 32'hFFFFFFFF);
        rd_chk('h184, 32'hF0000000, "R6");
        rd_chk('h185, 32'hF0000000, "R6");
        rd_chk('h190, 32'hC0000000, "R6");
        rd_chk('h191, 32'hC0000000, "R6");

        // R7 write-one-to-clear
        cur_req = "R7";
        @(negedge clk); err_set = 32'hA5A50F0F; tx_eob_set = 32'hFF; rx_derr_set = 32'h3;
        @(negedge clk); err_set = 0; tx_eob_set = 0; rx_derr_set = 0;
        rd_chk('h181, 32'hA5A50F0F, "R7");
        wr('h181, 32'h00000F00);
        rd_chk('h181, 32'hA5A5000F, "R7");
        wr('h186, 32'h0F);
        rd_chk('h186, 32'hF0, "R7");
        wr('h193, 32'h1);
        rd_chk('h193, 32'h2, "R7");

        // R8 set wins over same-cycle clear
        cur_req = "R8";
        @(negedge clk);
        bus_addr = 10'h187; bus_wdata = 32'hFFFFFFFF; bus_wr = 1'b1; tx_derr_set = 32'h8;
        @(negedge clk);
        bus_wr = 1'b0; tx_derr_set = 0;
        rd_chk('h187, 32'h8, "R8");
        @(negedge clk); rx_eob_set = 32'h40;
        @(negedge clk); rx_eob_set = 0;
        rd_chk('h192, 32'h40, "R8");

        // R9 pointer tables
        cur_req = "R9";
        for (int i = 0; i < TX_CH; i++) wr('h1A0 + i, 32'hC0DE0000 + i);
        for (int i = 0; i < RX_CH; i++) wr('h1C0 + i, 32'hFACE0000 + 32'(i * 16));
        for (int i = 0; i < TX_CH; i++) rd_chk('h1A0 + i, 32'hC0DE0000 + i, "R9");
        rd_chk('h1C1, 32'hFACE0010, "R9");

        // R10 buffer sizes
        cur_req = "R10";
        wr('h1E0, 32'h12345678); wr('h1E1, 32'hFFFFFF9A);
        rd_chk('h1E0, 32'h78, "R10");
        rd_chk('h1E1, 32'h9A, "R10");

        // R11 unmapped holes
        cur_req = "R11";
        wr('h1A0 + TX_CH, 32'hDEADBEEF);
        wr('h1C0 + RX_CH, 32'hDEADBEEF);
        wr('h1E0 + RX_CH, 32'hDEADBEEF);
        wr('h183, 32'hDEADBEEF);
        rd_chk('h1A0 + TX_CH, 32'h0, "R11");
        rd_chk('h1C0 + RX_CH, 32'h0, "R11");
        rd_chk('h1E0 + RX_CH, 32'h0, "R11");
        rd_chk('h183, 32'h0, "R11");
        rd_chk('h1A0 + TX_CH - 1, 32'hC0DE0000 + TX_CH - 1, "R11");
        rd_chk('h1C1, 32'hFACE0010, "R11");

        // R2 hold and read-before-write
        cur_req = "R2";
        rd_chk('h182, 32'h1F, "R2");
        repeat (3) @(negedge clk);
        chk("R2", "rdata held", bus_rdata, 32'h1F);
        @(negedge clk);
        bus_addr = 10'h182; bus_wdata = 32'h3; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R2", "read old value", bus_rdata, 32'h1F);
        rd_chk('h182, 32'h3, "R2");

        // R4 soft reset
        cur_req = "R4";
        wr('h180, 32'h80000001);
        rd_chk('h180, 32'h1, "R4");
        rd_chk('h182, 32'h0, "R4");
        rd_chk('h184, 32'h0, "R4");
        rd_chk('h190, 32'h0, "R4");
        rd_chk('h181, 32'h0, "R4");
        rd_chk('h192, 32'h0, "R4");
        rd_chk('h1A0, 32'hC0DE0000, "R4");
        rd_chk('h1E0, 32'h78, "R4");

        // R8 set beats soft reset
        cur_req = "R8";
        @(negedge clk);
        bus_addr = 10'h180; bus_wdata = 32'h80000000; bus_wr = 1'b1; err_set = 32'h10;
        @(negedge clk);
        bus_wr = 1'b0; err_set = 0;
        rd_chk('h181, 32'h10, "R8");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule